// File: doc/BRIEF.md
# Minute Alarm Comparator with Level Interrupt

This block watches a running calendar and raises an alarm when the current minute, hour, day of month and day of week agree with four host-programmed alarm values. Each alarm value is a BCD byte, and its top bit takes that field out of the comparison. The seconds field is never compared. It only marks the instant of evaluation: the comparison is sampled once, when seconds roll over to 00.

A successful comparison sets a sticky flag. The host reads the flag through a small register interface and clears it by writing 0 to its bit. While the flag and the host's enable bit are both set, an active-low interrupt line is held low. The calendar counter that supplies the time fields, and the serial bus that carries host accesses, sit outside this block.

Top module: `alm_comparator`

## Requirements
- R1: After reset the flag and enable are 0, the interrupt line is high, every alarm register reads 8'h80 (field excluded), and the control register at address 1 reads 8'h00.
- R2: At a minute boundary (seconds input changes from nonzero to 8'h00), if every alarm field is included and equal to its calendar field, the flag (control bit 3) becomes 1 on the next clock edge.
- R3: An alarm register with bit 7 set is excluded, so a mismatch in that field does not prevent the alarm.
- R4: A mismatch in any included field keeps the flag at 0 at the minute boundary.
- R5: If all four alarm registers have bit 7 set, the flag never sets.
- R6: The comparison is made only at the minute boundary: changes of the time fields at other moments, and seconds remaining at 00, do not set the flag.
- R7: alarm_irq_n is low exactly while the flag and the enable (control bit 1) are both 1.
- R8: A host write to address 1 with bit 3 = 0 clears the flag, and with bit 3 = 1 leaves the flag unchanged, so software cannot set it.
- R9: The flag sets even with the enable at 0, and the interrupt line falls one clock after the host later writes the enable to 1.
- R10: The alarm registers are at addresses 9 (minute), 10 (hour), 11 (day of month) and 12 (day of week) and read back as written. The control register reads back only bit 3 (flag) and bit 1 (enable), with all other bits 0.
- R11: Comparison uses only the valid BCD bits of each field: minute 7 bits, hour 6 bits, day of month 6 bits, day of week 3 bits. Other bits of both operands are ignored.
- R12: If a minute-boundary match and a host clear of the flag occur in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cal_sec | input | 8 | Calendar seconds, BCD |
| cal_min | input | 8 | Calendar minutes, BCD |
| cal_hour | input | 8 | Calendar hours, BCD |
| cal_mday | input | 8 | Calendar day of month, BCD |
| cal_wday | input | 8 | Calendar day of week, BCD |
| host_wr | input | 1 | Host register write strobe |
| host_addr | input | 4 | Host register address |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data, combinational from address |
| alarm_flag | output | 1 | Sticky alarm flag |
| alarm_ie | output | 1 | Alarm interrupt enable |
| alarm_irq_n | output | 1 | Active-low level interrupt |

## Verification
The comparator is driven with calendars that agree on all four fields, disagree only in an excluded field, disagree in the minute or weekday field, and carry stray bits above each field's BCD width. Together these separate a correct per-field exclude-and-mask from one that compares raw bytes or ignores the exclude bit. Timing patterns change the time mid-minute, hold seconds at 00 for several cycles, and collide a flag clear with a match, which separates edge-triggered evaluation from level evaluation and shows the priority of set over clear. Enable-after-flag and write-one sequences show that the interrupt is a level and that software cannot set the flag.

// File: rtl/alm_pkg.sv
package alm_pkg;
   localparam int unsigned NUM_FIELDS = 4;
   localparam int unsigned FLAG_BIT   = 3;
   localparam int unsigned IE_BIT     = 1;
   localparam int unsigned OFF_BIT    = 7;

   typedef enum logic [1:0] {
      FLD_MIN  = 2'd0,
      FLD_HOUR = 2'd1,
      FLD_MDAY = 2'd2,
      FLD_WDAY = 2'd3
   } field_e;

   // valid BCD bits of each compared field
   function automatic logic [7:0] field_mask(input int unsigned idx);
      case (idx)
         0:       field_mask = 8'h7F;
         1:       field_mask = 8'h3F;
         2:       field_mask = 8'h3F;
         default: field_mask = 8'h07;
      endcase
   endfunction
endpackage

// File: rtl/alm_tick.sv
module alm_tick #(
   parameter int unsigned W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] sec,
   output logic         tick
);
   logic [W-1:0] sec_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sec_q <= '0;
      else        sec_q <= sec;
   end

   // one-cycle event when seconds arrive at zero from a nonzero value
   assign tick = (sec == '0) && (sec_q != '0);

   a_r6_single_tick: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> !tick);
endmodule

// File: rtl/alm_field_cmp.sv
module alm_field_cmp #(
   parameter int unsigned W       = 8,
   parameter logic [W-1:0] MASK   = '1,
   parameter int unsigned OFF_BIT = 7
) (
   input  logic [W-1:0] alarm_val,
   input  logic [W-1:0] cal_val,
   output logic         included,
   output logic         hit
);
   if (OFF_BIT >= W) begin : g_bad_off
      $error("alm_field_cmp: OFF_BIT outside field width");
   end
   if (MASK[OFF_BIT]) begin : g_bad_mask
      $error("alm_field_cmp: MASK overlaps the exclude bit");
   end

   assign included = !alarm_val[OFF_BIT];
   assign hit      = ((alarm_val & MASK) == (cal_val & MASK));
endmodule

// File: rtl/alm_regs.sv
module alm_regs
   import alm_pkg::*;
#(
   parameter int unsigned W         = 8,
   parameter int unsigned ADDR_W    = 4,
   parameter int unsigned NF        = NUM_FIELDS,
   parameter int unsigned CTRL_ADDR = 1,
   parameter int unsigned ALM_BASE  = 9
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr,
   input  logic [ADDR_W-1:0]    addr,
   input  logic [W-1:0]         wdata,
   output logic [W-1:0]         rdata,
   input  logic                 set_evt,
   output logic [NF-1:0][W-1:0] alm,
   output logic                 flag,
   output logic                 ie
);
   localparam logic [W-1:0]      OFF_RESET = W'(1) << OFF_BIT;
   localparam logic [ADDR_W-1:0] CTRL_A    = ADDR_W'(CTRL_ADDR);

   logic ctrl_wr;
   assign ctrl_wr = wr && (addr == CTRL_A);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag <= 1'b0;
         ie   <= 1'b0;
      end else begin
         if (set_evt)      flag <= 1'b1;
         else if (ctrl_wr) flag <= flag & wdata[FLAG_BIT];
         if (ctrl_wr)      ie   <= wdata[IE_BIT];
      end
   end

   for (genvar i = 0; i < NF; i++) begin : g_alm
      localparam logic [ADDR_W-1:0] MY_A = ADDR_W'(ALM_BASE + i);
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                    alm[i] <= OFF_RESET;
         else if (wr && addr == MY_A)   alm[i] <= wdata;
      end
   end

   always_comb begin
      rdata = '0;
      if (addr == CTRL_A) begin
         rdata[FLAG_BIT] = flag;
         rdata[IE_BIT]   = ie;
      end
      for (int i = 0; i < int'(NF); i++) begin
         if (addr == ADDR_W'(ALM_BASE + i)) rdata = alm[i];
      end
   end

   // R8: software cannot create the flag
   a_r8_no_sw_set: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(set_evt) && !$past(flag)) |-> !flag);
   // R8: a clear write without a concurrent match leaves the flag at 0
   a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_wr && !wdata[FLAG_BIT] && !set_evt) |=> !flag);
   // R12: a match always wins over a clear
   a_r12_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      set_evt |=> flag);
   // R6: the flag only rises after a match event
   a_r6_rise_cause: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag) |-> $past(set_evt));
endmodule

// File: rtl/alm_comparator.sv
module alm_comparator
   import alm_pkg::*;
#(
   parameter int unsigned W         = 8,
   parameter int unsigned ADDR_W    = 4,
   parameter int unsigned CTRL_ADDR = 1,
   parameter int unsigned ALM_BASE  = 9
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [W-1:0]      cal_sec,
   input  logic [W-1:0]      cal_min,
   input  logic [W-1:0]      cal_hour,
   input  logic [W-1:0]      cal_mday,
   input  logic [W-1:0]      cal_wday,
   input  logic              host_wr,
   input  logic [ADDR_W-1:0] host_addr,
   input  logic [W-1:0]      host_wdata,
   output logic [W-1:0]      host_rdata,
   output logic              alarm_flag,
   output logic              alarm_ie,
   output logic              alarm_irq_n
);
   localparam int unsigned NF = NUM_FIELDS;

   if (W < 8) begin : g_bad_w
      $error("alm_comparator: W must hold a BCD byte with exclude bit");
   end
   if (ALM_BASE + NF > (1 << ADDR_W)) begin : g_bad_map
      $error("alm_comparator: alarm registers exceed address space");
   end
   if (CTRL_ADDR >= ALM_BASE && CTRL_ADDR < ALM_BASE + NF) begin : g_bad_ctrl
      $error("alm_comparator: control address overlaps alarm registers");
   end

   logic [NF-1:0][W-1:0] alm;
   logic [NF-1:0][W-1:0] cal;
   logic [NF-1:0]        incl;
   logic [NF-1:0]        hit;
   logic                 tick;
   logic                 match;
   logic                 set_evt;

   assign cal[FLD_MIN]  = cal_min;
   assign cal[FLD_HOUR] = cal_hour;
   assign cal[FLD_MDAY] = cal_mday;
   assign cal[FLD_WDAY] = cal_wday;

   alm_tick #(.W(W)) u_tick (
      .clk  (clk),
      .rst_n(rst_n),
      .sec  (cal_sec),
      .tick (tick)
   );

   for (genvar i = 0; i < NF; i++) begin : g_cmp
      alm_field_cmp #(
         .W      (W),
         .MASK   (W'(field_mask(i))),
         .OFF_BIT(OFF_BIT)
      ) u_cmp (
         .alarm_val(alm[i]),
         .cal_val  (cal[i]),
         .included (incl[i]),
         .hit      (hit[i])
      );
   end

   // every included field agrees, and at least one field is included
   assign match   = (&(hit | ~incl)) && (|incl);
   assign set_evt = tick && match;

   alm_regs #(
      .W        (W),
      .ADDR_W   (ADDR_W),
      .NF       (NF),
      .CTRL_ADDR(CTRL_ADDR),
      .ALM_BASE (ALM_BASE)
   ) u_regs (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr     (host_wr),
      .addr   (host_addr),
      .wdata  (host_wdata),
      .rdata  (host_rdata),
      .set_evt(set_evt),
      .alm    (alm),
      .flag   (alarm_flag),
      .ie     (alarm_ie)
   );

   assign alarm_irq_n = !(alarm_flag && alarm_ie);

   // R5: with every field excluded the flag cannot rise
   a_r5_all_off: assert property (@(posedge clk) disable iff (!rst_n)
      (incl == '0) |=> !$rose(alarm_flag));
   // R7: the interrupt only falls after a match or a host write
   a_r7_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(alarm_irq_n) |-> ($past(set_evt) || $past(host_wr)));
   // R7: the interrupt line is never low without the enable
   a_r7_irq_needs_ie: assert property (@(posedge clk) disable iff (!rst_n)
      !alarm_irq_n |-> alarm_ie);
endmodule

// File: tb/alm_comparator_bench.sv
module alm_comparator_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] cal_sec = 8'h00, cal_min = 8'h00, cal_hour = 8'h00;
   logic [7:0] cal_mday = 8'h01, cal_wday = 8'h00;
   logic       host_wr = 1'b0;
   logic [3:0] host_addr = 4'd0;
   logic [7:0] host_wdata = 8'h00;
   logic [7:0] host_rdata;
   logic       alarm_flag, alarm_ie, alarm_irq_n;

   int n_chk = 0;
   int n_fail = 0;

   always #5 clk = ~clk;

   alm_comparator u_alm_comparator (
      .clk(clk), .rst_n(rst_n),
      .cal_sec(cal_sec), .cal_min(cal_min), .cal_hour(cal_hour),
      .cal_mday(cal_mday), .cal_wday(cal_wday),
      .host_wr(host_wr), .host_addr(host_addr), .host_wdata(host_wdata),
      .host_rdata(host_rdata), .alarm_flag(alarm_flag),
      .alarm_ie(alarm_ie), .alarm_irq_n(alarm_irq_n)
   );

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [7:0] d);
      host_wr = 1'b1; host_addr = a; host_wdata = d;
      @(negedge clk);
      host_wr = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [7:0] d);
      host_addr = a;
      #1;
      d = host_rdata;
   endtask

   task automatic set_alarm(input logic [7:0] m, h, d, w);
      wr(4'd9, m); wr(4'd10, h); wr(4'd11, d); wr(4'd12, w);
   endtask

   task automatic set_cal(input logic [7:0] m, h, d, w);
      cal_min = m; cal_hour = h; cal_mday = d; cal_wday = w;
      @(negedge clk);
   endtask

   // seconds 59 -> 00; sample after the edge that sees the rollover
   task automatic minute_roll;
      cal_sec = 8'h59;
      @(negedge clk);
      cal_sec = 8'h00;
      @(negedge clk);
   endtask

   task automatic clear_flag;
      wr(4'd1, {6'b0, alarm_ie, 1'b0});
   endtask

   task automatic t_reset;
      logic [7:0] d;
      chk("R1 flag", {7'b0, alarm_flag}, 8'h00);
      chk("R1 irq_n", {7'b0, alarm_irq_n}, 8'h01);
      for (int a = 9; a <= 12; a++) begin
         rd(4'(a), d);
         chk("R1 alarm reg", d, 8'h80);
      end
      rd(4'd1, d);
      chk("R1 ctrl", d, 8'h00);
   endtask

   task automatic t_full_match;
      set_alarm(8'h30, 8'h12, 8'h15, 8'h03);
      wr(4'd1, 8'h02);
      cal_sec = 8'h20;
      set_cal(8'h30, 8'h12, 8'h15, 8'h03);
      chk("R6 no flag mid-minute", {7'b0, alarm_flag}, 8'h00);
      minute_roll();
      chk("R2 full match flag", {7'b0, alarm_flag}, 8'h01);
      chk("R7 irq low", {7'b0, alarm_irq_n}, 8'h00);
      wr(4'd1, 8'h02);
      chk("R8 cleared", {7'b0, alarm_flag}, 8'h00);
      chk("R7 irq released", {7'b0, alarm_irq_n}, 8'h01);
   endtask

   task automatic t_excluded;
      set_alarm(8'h30, 8'h85, 8'h15, 8'h03);
      set_cal(8'h30, 8'h22, 8'h15, 8'h03);
      minute_roll();
      chk("R3 excluded hour", {7'b0, alarm_flag}, 8'h01);
      clear_flag();
   endtask

   task automatic t_mismatch;
      set_alarm(8'h31, 8'h12, 8'h15, 8'h03);
      set_cal(8'h30, 8'h12, 8'h15, 8'h03);
      minute_roll();
      chk("R4 minute mismatch", {7'b0, alarm_flag}, 8'h00);
      set_alarm(8'h30, 8'h12, 8'h15, 8'h04);
      minute_roll();
      chk("R4 weekday mismatch", {7'b0, alarm_flag}, 8'h00);
      chk("R4 irq idle", {7'b0, alarm_irq_n}, 8'h01);
   endtask

   task automatic t_all_off;
      set_alarm(8'h80, 8'h80, 8'h80, 8'h80);
      minute_roll();
      chk("R5 all excluded", {7'b0, alarm_flag}, 8'h00);
   endtask

   task automatic t_once;
      set_alarm(8'h45, 8'h08, 8'h01, 8'h06);
      set_cal(8'h45, 8'h08, 8'h01, 8'h06);
      minute_roll();
      chk("R6 set at boundary", {7'b0, alarm_flag}, 8'h01);
      clear_flag();
      repeat (5) @(negedge clk);
      chk("R6 seconds held at 00", {7'b0, alarm_flag}, 8'h00);
      cal_sec = 8'h01; @(negedge clk);
      cal_sec = 8'h02; @(negedge clk);
      chk("R6 seconds counting", {7'b0, alarm_flag}, 8'h00);
   endtask

   task automatic t_write_one;
      logic [7:0] d;
      wr(4'd1, 8'h0A);
      chk("R8 write 1 no set", {7'b0, alarm_flag}, 8'h00);
      minute_roll();
      wr(4'd1, 8'h0A);
      chk("R8 write 1 keeps flag", {7'b0, alarm_flag}, 8'h01);
      rd(4'd1, d);
      chk("R10 ctrl readback", d, 8'h0A);
      wr(4'd1, 8'hF7);
      rd(4'd1, d);
      chk("R10 ctrl other bits zero", d, 8'h02);
   endtask

   task automatic t_late_enable;
      wr(4'd1, 8'h00);
      minute_roll();
      chk("R9 flag without enable", {7'b0, alarm_flag}, 8'h01);
      chk("R9 irq idle", {7'b0, alarm_irq_n}, 8'h01);
      wr(4'd1, 8'h0A);
      chk("R9 irq after enable", {7'b0, alarm_irq_n}, 8'h00);
      wr(4'd1, 8'h08);
      chk("R7 irq off by enable", {7'b0, alarm_irq_n}, 8'h01);
      chk("R7 flag kept", {7'b0, alarm_flag}, 8'h01);
      wr(4'd1, 8'h00);
   endtask

   task automatic t_readback;
      logic [7:0] d;
      wr(4'd9, 8'h45); wr(4'd10, 8'h93); wr(4'd11, 8'h27); wr(4'd12, 8'h05);
      rd(4'd9, d);  chk("R10 minute reg", d, 8'h45);
      rd(4'd10, d); chk("R10 hour reg", d, 8'h93);
      rd(4'd11, d); chk("R10 mday reg", d, 8'h27);
      rd(4'd12, d); chk("R10 wday reg", d, 8'h05);
   endtask

   task automatic t_mask;
      set_alarm(8'h20, 8'h52, 8'hC9 & 8'h7F, 8'h7B);
      set_cal(8'hA0, 8'h12, 8'h09, 8'h03);
      minute_roll();
      chk("R11 masked compare", {7'b0, alarm_flag}, 8'h01);
      clear_flag();
   endtask

   task automatic t_set_wins;
      set_alarm(8'h10, 8'h10, 8'h10, 8'h01);
      set_cal(8'h10, 8'h10, 8'h10, 8'h01);
      cal_sec = 8'h59;
      @(negedge clk);
      cal_sec = 8'h00;
      host_wr = 1'b1; host_addr = 4'd1; host_wdata = 8'h00;
      @(negedge clk);
      host_wr = 1'b0;
      chk("R12 set beats clear", {7'b0, alarm_flag}, 8'h01);
      clear_flag();
   endtask

   initial begin
      #2_000_000;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_full_match();
      t_excluded();
      t_mismatch();
      t_all_off();
      t_once();
      t_write_one();
      t_late_enable();
      t_readback();
      t_mask();
      t_set_wins();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end
endmodule